// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the arithmetic and logic stage of a small RISC core. On each cycle it takes an operation code, a destination operand and a source operand, and forms a data-width result with no clock in the path. Beside the result it keeps a four-bit condition register. A caller that wants the flags of an operation saved raises the valid strobe in the same cycle, and the register loads on the next rising edge.

The operations are add, subtract, three bitwise operations, four shift and rotate variants, and unsigned and signed half-width multiplies. Shifts have defined results for every count, including zero and counts at or past the word width. A shift also reports the last bit it pushed out, and whether the sign bit changed. The multiplies read only the low half of each operand. Opcode values with no operation behind them give a zero result and leave the flags as they are.

Top module: `int_alu_cc`

## Requirements
- R1: Opcode 0 gives A+B; carry is the carry out of the top bit, and overflow is set when both operands have the same sign and the sum's sign differs. Opcode 1 gives A-B; carry is set when a borrow occurs (A < B unsigned), and overflow is set when the operand signs differ and the result's sign differs from A's.
- R2: Opcodes 2, 3 and 4 give A AND B, A OR B and A XOR B, and clear carry and overflow.
- R3: The flag register packs zero in bit 0, carry in bit 1, negative in bit 2 and overflow in bit 3. For every defined opcode, zero is set when the result is all zeros, and negative copies the result's top bit.
- R4: Opcode 5 is a logical right shift and opcode 7 a logical left shift of A, by the count in B bits 5:0. Carry holds the last bit shifted out. Overflow is set when the result's top bit differs from A's. Counts of 32 or more give 0.
- R5: Opcode 6 is an arithmetic right shift of A by B bits 5:0. Carry holds the last bit shifted out, counts of 32 or more give all copies of A's sign bit, and overflow is always clear.
- R6: A shift (opcodes 5, 6, 7) by a count of 0 returns A unchanged and clears carry and overflow.
- R7: Opcode 8 rotates A left by B bits 4:0, so the count is taken modulo 32. Carry is the bit that wrapped into bit 0 last, and is clear for a rotation by 0. Overflow is clear.
- R8: Opcode 9 multiplies the low 16 bits of A and B as unsigned numbers into a 32-bit product, and clears carry and overflow.
- R9: Opcode 10 multiplies the low 16 bits of A and B as two's complement numbers into a 32-bit product, and clears carry and overflow.
- R10: The flag register loads only when the valid strobe is high and the opcode is 0 to 10. Opcodes 11 to 15 give a result of 0 and never change the flags. A synchronous reset clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag register loads on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the flags |
| opValid | input | 1 | Saves this cycle's flags when high |
| opCode | input | 4 | Operation select |
| opA | input | 32 | Destination operand |
| opB | input | 32 | Source operand or immediate; its low bits carry the shift count |
| result | output | 32 | Combinational result |
| ccFlags | output | 4 | Registered condition flags {overflow, negative, carry, zero} |

## Verification
The bench builds the block with its default width of 32. This makes the 6-bit shift count able to reach the range from 32 to 63, so the saturation and sign-fill behaviour of the shifts is tested, and the 16-bit multiply halves can be checked against known products. Random operands are weighted toward the sign boundary, all-ones and small counts. Directed cases cover the carry, borrow and overflow edges, reserved opcodes, idle cycles, and a reset in the middle of the run.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int OPC_W = 4;

  // Opcode values seen at the top-level port
  localparam logic [OPC_W-1:0] OPC_ADD  = 4'd0;
  localparam logic [OPC_W-1:0] OPC_SUB  = 4'd1;
  localparam logic [OPC_W-1:0] OPC_AND  = 4'd2;
  localparam logic [OPC_W-1:0] OPC_OR   = 4'd3;
  localparam logic [OPC_W-1:0] OPC_XOR  = 4'd4;
  localparam logic [OPC_W-1:0] OPC_LSR  = 4'd5;
  localparam logic [OPC_W-1:0] OPC_ASR  = 4'd6;
  localparam logic [OPC_W-1:0] OPC_LSL  = 4'd7;
  localparam logic [OPC_W-1:0] OPC_ROL  = 4'd8;
  localparam logic [OPC_W-1:0] OPC_MPYU = 4'd9;
  localparam logic [OPC_W-1:0] OPC_MPYS = 4'd10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ADDER,
    SEL_LOGIC,
    SEL_SHIFT,
    SEL_MUL
  } resSel_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_XOR
  } logicOp_e;

  typedef enum logic [1:0] {
    SH_LSR,
    SH_ASR,
    SH_LSL,
    SH_ROL
  } shiftOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    resSel_e  resSel;
    logic     subtract;
    logicOp_e logicOp;
    shiftOp_e shiftOp;
    logic     mulSigned;
    logic     ccLoad;
  } aluCtrl_t;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic             opValid,
  input  logic [OPC_W-1:0] opCode,
  output aluCtrl_t         ctrl
);

  always_comb begin
    ctrl.resSel    = SEL_NONE;
    ctrl.subtract  = 1'b0;
    ctrl.logicOp   = LG_AND;
    ctrl.shiftOp   = SH_LSR;
    ctrl.mulSigned = 1'b0;
    unique case (opCode)
      OPC_ADD:  ctrl.resSel = SEL_ADDER;
      OPC_SUB: begin
        ctrl.resSel   = SEL_ADDER;
        ctrl.subtract = 1'b1;
      end
      OPC_AND: begin
        ctrl.resSel  = SEL_LOGIC;
        ctrl.logicOp = LG_AND;
      end
      OPC_OR: begin
        ctrl.resSel  = SEL_LOGIC;
        ctrl.logicOp = LG_OR;
      end
      OPC_XOR: begin
        ctrl.resSel  = SEL_LOGIC;
        ctrl.logicOp = LG_XOR;
      end
      OPC_LSR: begin
        ctrl.resSel  = SEL_SHIFT;
        ctrl.shiftOp = SH_LSR;
      end
      OPC_ASR: begin
        ctrl.resSel  = SEL_SHIFT;
        ctrl.shiftOp = SH_ASR;
      end
      OPC_LSL: begin
        ctrl.resSel  = SEL_SHIFT;
        ctrl.shiftOp = SH_LSL;
      end
      OPC_ROL: begin
        ctrl.resSel  = SEL_SHIFT;
        ctrl.shiftOp = SH_ROL;
      end
      OPC_MPYU: ctrl.resSel = SEL_MUL;
      OPC_MPYS: begin
        ctrl.resSel    = SEL_MUL;
        ctrl.mulSigned = 1'b1;
      end
      default:  ctrl.resSel = SEL_NONE;
    endcase
    ctrl.ccLoad = opValid && (ctrl.resSel != SEL_NONE);
  end

endmodule

// File: rtl/int_alu_datapath.sv
module int_alu_datapath
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        ccFlags
);

  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W) + 1;
  localparam int ROT_W  = CNT_W - 1;
  localparam int MSB    = DATA_W - 1;

  // Adder / subtractor
  logic [DATA_W-1:0] bEff;
  logic [DATA_W:0]   addFull;
  assign bEff    = ctrl.subtract ? ~opB : opB;
  assign addFull = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, ctrl.subtract};

  // Shifters: one spare bit catches the last bit pushed out
  logic [CNT_W-1:0]         shCnt;
  logic [ROT_W-1:0]         rotCnt;
  logic [DATA_W:0]          lsrExt;
  logic [DATA_W:0]          lslExt;
  logic signed [DATA_W:0]   asrIn;
  logic signed [DATA_W:0]   asrExt;
  logic [DATA_W-1:0]        rolRes;
  assign shCnt  = opB[CNT_W-1:0];
  assign rotCnt = opB[ROT_W-1:0];
  assign lsrExt = {opA, 1'b0} >> shCnt;
  assign lslExt = {1'b0, opA} << shCnt;
  assign asrIn  = {opA, 1'b0};
  assign asrExt = asrIn >>> shCnt;
  assign rolRes = (rotCnt == '0) ? opA
                : ((opA << rotCnt) | (opA >> (DATA_W - int'(rotCnt))));

  // Half-width multipliers; low word of the product is kept
  logic [DATA_W-1:0] mulAu, mulBu, mulAs, mulBs, mulU, mulS;
  assign mulAu = {{HALF_W{1'b0}}, opA[HALF_W-1:0]};
  assign mulBu = {{HALF_W{1'b0}}, opB[HALF_W-1:0]};
  assign mulAs = {{HALF_W{opA[HALF_W-1]}}, opA[HALF_W-1:0]};
  assign mulBs = {{HALF_W{opB[HALF_W-1]}}, opB[HALF_W-1:0]};
  assign mulU  = mulAu * mulBu;
  assign mulS  = mulAs * mulBs;

  logic carryNext, ovfNext;

  always_comb begin
    result    = '0;
    carryNext = 1'b0;
    ovfNext   = 1'b0;
    unique case (ctrl.resSel)
      SEL_ADDER: begin
        result    = addFull[MSB:0];
        carryNext = addFull[DATA_W] ^ ctrl.subtract;
        ovfNext   = (opA[MSB] == bEff[MSB]) && (result[MSB] != opA[MSB]);
      end
      SEL_LOGIC: begin
        unique case (ctrl.logicOp)
          LG_OR:   result = opA | opB;
          LG_XOR:  result = opA ^ opB;
          default: result = opA & opB;
        endcase
      end
      SEL_SHIFT: begin
        unique case (ctrl.shiftOp)
          SH_LSR: begin
            result    = lsrExt[DATA_W:1];
            carryNext = lsrExt[0];
            ovfNext   = opA[MSB] ^ result[MSB];
          end
          SH_ASR: begin
            result    = asrExt[DATA_W:1];
            carryNext = asrExt[0];
          end
          SH_LSL: begin
            result    = lslExt[MSB:0];
            carryNext = lslExt[DATA_W];
            ovfNext   = opA[MSB] ^ result[MSB];
          end
          default: begin
            result    = rolRes;
            carryNext = (rotCnt != '0) && rolRes[0];
          end
        endcase
      end
      SEL_MUL: result = ctrl.mulSigned ? mulS : mulU;
      default: result = '0;
    endcase
  end

  logic [3:0] ccReg;
  always_ff @(posedge clk) begin
    if (rst) begin
      ccReg <= 4'b0000;
    end else if (ctrl.ccLoad) begin
      ccReg <= {ovfNext, result[MSB], carryNext, (result == '0)};
    end
  end
  assign ccFlags = ccReg;

endmodule

// File: rtl/int_alu_cc.sv
module int_alu_cc
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic [OPC_W-1:0]  opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        ccFlags
);

  aluCtrl_t ctrl;

  int_alu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .ctrl    (ctrl)
  );

  int_alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .ccFlags (ccFlags)
  );

endmodule

// File: rtl/int_alu_cc_checker.sv
module int_alu_cc_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        ccFlags
);

  localparam int CNT_W = $clog2(DATA_W) + 1;

  logic definedOp, isShift, isLogic;
  assign definedOp = (opCode <= 4'd10);
  assign isShift   = (opCode >= 4'd5) && (opCode <= 4'd7);
  assign isLogic   = (opCode >= 4'd2) && (opCode <= 4'd4);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!opValid || !definedOp) |=> $stable(ccFlags));

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ccFlags == 4'b0000));

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !definedOp |-> (result == '0));

  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (opValid && definedOp) |=> (ccFlags[0] == ($past(result) == '0)));

  // R3
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (opValid && definedOp) |=> (ccFlags[2] == $past(result[DATA_W-1])));

  // R2
  logic_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (opValid && isLogic) |=> (ccFlags[1] == 1'b0 && ccFlags[3] == 1'b0));

  // R5
  asr_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == 4'd6) |=> (ccFlags[3] == 1'b0));

  // R6
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (isShift && opB[CNT_W-1:0] == '0) |-> (result == opA));

endmodule

bind int_alu_cc int_alu_cc_checker #(.DATA_W(DATA_W)) u_cc_chk (
  .clk     (clk),
  .rst     (rst),
  .opValid (opValid),
  .opCode  (opCode),
  .opA     (opA),
  .opB     (opB),
  .result  (result),
  .ccFlags (ccFlags)
);

// File: tb/int_alu_cc_bench.sv
module int_alu_cc_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] result;
  logic [3:0]  ccFlags;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [3:0] expFlags = 4'b0000;

  always #10 clk = ~clk;

  int_alu_cc u_int_alu_cc (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .result(result), .ccFlags(ccFlags)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h (op=%0d a=%08h b=%08h)",
               tag, act, exp, opCode, opA, opB);
    end
  endtask

  // Reference: returns {v,n,c,z,result}; shifts step one bit at a time
  function automatic logic [35:0] refModel(input logic [3:0] op, input logic [31:0] a,
                                           input logic [31:0] b);
    logic [31:0] r = '0;
    logic c = 1'b0, v = 1'b0;
    int cnt = int'(b[5:0]);
    case (op)
      4'd0: begin
        {c, r} = 33'(a) + 33'(b);
        v = (a[31] == b[31]) && (r[31] != a[31]);
      end
      4'd1: begin
        r = a - b;
        c = (a < b);
        v = (a[31] != b[31]) && (r[31] != a[31]);
      end
      4'd2: r = a & b;
      4'd3: r = a | b;
      4'd4: r = a ^ b;
      4'd5: begin
        r = a;
        for (int i = 0; i < cnt; i++) begin c = r[0]; r = r >> 1; end
        v = a[31] ^ r[31];
      end
      4'd6: begin
        r = a;
        for (int i = 0; i < cnt; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
      end
      4'd7: begin
        r = a;
        for (int i = 0; i < cnt; i++) begin c = r[31]; r = r << 1; end
        v = a[31] ^ r[31];
      end
      4'd8: begin
        r = a;
        for (int i = 0; i < (cnt % 32); i++) begin c = r[31]; r = {r[30:0], r[31]}; end
      end
      4'd9:  r = a[15:0] * b[15:0];
      4'd10: r = 32'($signed(a[15:0]) * $signed(b[15:0]));
      default: r = '0;
    endcase
    return {v, r[31], c, (r == 0), r};
  endfunction

  function automatic string tagFor(input logic [3:0] op, input logic [31:0] b);
    if (op >= 4'd5 && op <= 4'd7 && b[5:0] == 6'd0) return "R6";
    case (op)
      4'd0, 4'd1:       return "R1";
      4'd2, 4'd3, 4'd4: return "R2";
      4'd5, 4'd7:       return "R4";
      4'd6:             return "R5";
      4'd8:             return "R7";
      4'd9:             return "R8";
      4'd10:            return "R9";
      default:          return "R10";
    endcase
  endfunction

  task automatic runOp(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic vld);
    logic [35:0] m;
    @(negedge clk);
    opCode = op; opA = a; opB = b; opValid = vld;
    m = refModel(op, a, b);
    #5;
    check(tagFor(op, b), result, m[31:0]);
    if (vld && op <= 4'd10) expFlags = m[35:32];
    @(posedge clk);
    #5;
    if (vld && op <= 4'd10) check("R3", {28'd0, ccFlags}, {28'd0, expFlags});
    else                    check("R10", {28'd0, ccFlags}, {28'd0, expFlags});
  endtask

  function automatic logic [31:0] pickVal();
    case ($urandom % 8)
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_FFFF;
      3: return 32'($urandom % 70);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    if (!finished) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seedInit = $urandom(32'h1A2B_3C4D);
    if (seedInit == 0) seedInit = 1;
    repeat (3) @(posedge clk);
    #5;
    check("R10", {28'd0, ccFlags}, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R1 corners
    runOp(4'd0, 32'h7FFF_FFFF, 32'd1, 1'b1);
    check("R1", {28'd0, ccFlags}, 32'b1100);
    runOp(4'd0, 32'hFFFF_FFFF, 32'd1, 1'b1);
    check("R1", {28'd0, ccFlags}, 32'b0011);
    runOp(4'd1, 32'h8000_0000, 32'd1, 1'b1);
    check("R1", {28'd0, ccFlags}, 32'b1000);
    runOp(4'd1, 32'd0, 32'd1, 1'b1);
    check("R1", {28'd0, ccFlags}, 32'b0110);
    // R4 shifts
    runOp(4'd5, 32'h8000_0000, 32'd1, 1'b1);
    check("R4", {28'd0, ccFlags}, 32'b1000);
    runOp(4'd7, 32'h4000_0000, 32'd1, 1'b1);
    check("R4", {28'd0, ccFlags}, 32'b1100);
    runOp(4'd7, 32'h8000_0000, 32'd1, 1'b1);
    check("R4", {28'd0, ccFlags}, 32'b1011);
    runOp(4'd5, 32'hFFFF_FFFF, 32'd32, 1'b1);
    check("R4", result, 32'd0);
    runOp(4'd5, 32'h7FFF_FFFF, 32'd31, 1'b1);
    check("R4", {28'd0, ccFlags}, 32'b0011);
    // R5 arithmetic shift
    runOp(4'd6, 32'hFFFF_FFFF, 32'd32, 1'b1);
    check("R5", result, 32'hFFFF_FFFF);
    runOp(4'd6, 32'h8000_0001, 32'd45, 1'b1);
    check("R5", result, 32'hFFFF_FFFF);
    // R6 zero count
    runOp(4'd5, 32'hFFFF_FFFF, 32'd0, 1'b1);
    check("R6", {28'd0, ccFlags}, 32'b0100);
    runOp(4'd7, 32'h1234_5678, 32'hFFFF_FFC0, 1'b1);
    check("R6", result, 32'h1234_5678);
    // R7 rotate modulo 32
    runOp(4'd8, 32'h8000_0001, 32'd33, 1'b1);
    check("R7", result, 32'h0000_0003);
    runOp(4'd8, 32'h8000_0000, 32'd32, 1'b1);
    check("R7", {28'd0, ccFlags}, 32'b0100);
    // R8 / R9 multiplies
    runOp(4'd9, 32'hABCD_FFFF, 32'h1234_FFFF, 1'b1);
    check("R8", result, 32'hFFFE_0001);
    runOp(4'd9, 32'd23171, 32'd23171, 1'b1);
    check("R8", result, 32'd536895241);
    runOp(4'd10, 32'h0000_8001, 32'h0000_7FFF, 1'b1);
    check("R9", result, 32'hC000_FFFF);
    runOp(4'd10, 32'hFFFF_8001, 32'h0000_8001, 1'b1);
    check("R9", result, 32'h3FFF_0001);
    runOp(4'd10, 32'h0000_8000, 32'h0000_8000, 1'b1);
    check("R9", result, 32'h4000_0000);
    // R10 hold cases
    runOp(4'd1, 32'd0, 32'd1, 1'b1);
    runOp(4'd13, 32'd5, 32'd5, 1'b1);
    check("R10", {28'd0, ccFlags}, 32'b0110);
    runOp(4'd0, 32'd0, 32'd0, 1'b0);
    check("R10", {28'd0, ccFlags}, 32'b0110);

    for (int i = 0; i < 3000; i++) begin
      runOp(4'($urandom % 16), pickVal(), pickVal(), ($urandom % 8) != 0);
    end

    // R10 reset in the middle of the run
    runOp(4'd1, 32'd0, 32'd1, 1'b1);
    @(negedge clk); rst = 1'b1; opValid = 1'b1;
    @(posedge clk); #5;
    check("R10", {28'd0, ccFlags}, 32'd0);
    @(negedge clk); rst = 1'b0; expFlags = 4'b0000;
    runOp(4'd2, 32'hF0F0_0000, 32'h0F0F_0000, 1'b1);
    check("R2", {28'd0, ccFlags}, 32'b0001);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule